// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous Memory

This block is a single-port synchronous memory whose word is split into four byte lanes. Its timing matches a pipelined burst cache memory. An external sequencer presents the array address each cycle. The block samples that address together with its enables on the rising clock edge and then performs a full-word write, a per-lane write or a read. With the default 9-bit lanes, each lane carries eight data bits plus one parity bit. With 8-bit lanes the word is 32 bits wide.

Read data normally passes through two register stages: the address register and the output register. A mode input can instead make the output register transparent, so data leaves after one stage. Output drive is reported on a separate enable pin and is never driven onto a shared bus here. This enable tracks the read pipeline, an asynchronous output-enable input and a power-down input.

Top module: `pbw_sram`

## Requirements
- R1: While reset is held, and after its release until a read reaches the output, `drive_en` is low.
- R2: With the chip selected, `glob_wr_n` low writes all four lanes from `wdata`, whatever `byte_wr_n` and `lane_n` show.
- R3: With `glob_wr_n` high and `byte_wr_n` low, lane i is written exactly when `lane_n[i]` is low. Lane i occupies bits `[i*LANE_W +: LANE_W]`, and lane 0 is the least significant.
- R4: With `glob_wr_n` high, a cycle where `byte_wr_n` is high, or where every `lane_n` bit is high, writes nothing and acts as a read.
- R5: On an edge where `proc_start` is high, all write enables are ignored and the cycle is a read.
- R6: A cycle that writes any lane gives `drive_en` low in that cycle's output slot, even with `out_en_n` low.
- R7: In pipelined mode (`flow_thru` low), a read sampled on edge k drives its data with `drive_en` high after edge k+1, and not after edge k.
- R8: In flow-through mode (`flow_thru` high), a read sampled on edge k drives its data after edge k.
- R9: `out_en_n` high forces `drive_en` low at once, without waiting for a clock edge.
- R10: With `sel_n` high, nothing is written and `drive_en` stays low in that cycle's output slot.
- R11: While `pwr_down` is high, no lane is written and `drive_en` is low. Stored contents are kept.
- R12: A read sampled on the edge after a write to the same address returns the new data in the written lanes and the old data in the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | AW | Array address from the sequencer |
| glob_wr_n | input | 1 | Active-low write of the whole word |
| byte_wr_n | input | 1 | Active-low qualifier for per-lane writes |
| lane_n | input | 4 | Active-low per-lane write selects |
| sel_n | input | 1 | Active-low chip select |
| proc_start | input | 1 | Marks a processor-started access; write enables ignored |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| flow_thru | input | 1 | 1 = single-register read path, 0 = two-stage pipeline |
| pwr_down | input | 1 | Power-down: blocks writes and output drive |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data |
| drive_en | output | 1 | Output-drive enable for the data bus |

## Verification
A lane write committing to the array and a read capture of the same address can occur on consecutive edges. This checks whether the read stage sees the array's post-write state. The bench provokes it by following a partial-lane write with a read of the same address on the very next edge, in both read modes. It judges the returned word lane by lane: new lanes from the write, untouched lanes from an earlier full-word fill. A second collision is a write slot arriving while `out_en_n` is asserted. For that case the bench expects `drive_en` low in the exact output cycle of the write.

// File: rtl/pbw_pkg.sv
`timescale 1ns/1ps
package pbw_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic {
    MODE_PIPE = 1'b0,
    MODE_FLOW = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/pbw_we_decode.sv
`timescale 1ns/1ps
// Write-enable decode: the whole-word write ranks above the lane writes.
module pbw_we_decode #(
  parameter int LANES = 4
) (
  input  logic             live,
  input  logic             sel_n,
  input  logic             pwr_down,
  input  logic             proc_start,
  input  logic             glob_wr_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] wr_lanes,
  output logic             rd_req
);
  logic             active;
  logic [LANES-1:0] lanes_raw;

  always_comb begin
    active = live && !sel_n && !pwr_down;
    if (!glob_wr_n) begin
      lanes_raw = '1;
    end else if (!byte_wr_n) begin
      lanes_raw = ~lane_n;
    end else begin
      lanes_raw = '0;
    end
    wr_lanes = (active && !proc_start) ? lanes_raw : '0;
    rd_req   = active && (wr_lanes == '0);
  end
endmodule

// File: rtl/pbw_array.sv
`timescale 1ns/1ps
// Storage split into one bank per lane; each bank has its own write strobe.
module pbw_array #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [LANES-1:0] wr_lanes,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) begin
        bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
  end
endmodule

// File: rtl/pbw_out_stage.sv
`timescale 1ns/1ps
// Output register, drive-enable delay line and read-mode selection.
module pbw_out_stage
  import pbw_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [DW-1:0] arr_data,
  input  rd_mode_e      mode,
  input  logic          pwr_down,
  input  logic          out_en_n,
  output logic [DW-1:0] rdata,
  output logic          drive_en
);
  logic          en1_d, en1_q, en2_d, en2_q;
  logic          stage_en;
  logic [DW-1:0] dat_q;

  always_comb begin
    en1_d = rd_req;
    en2_d = en1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en1_q <= 1'b0;
      en2_q <= 1'b0;
    end else begin
      en1_q <= en1_d;
      en2_q <= en2_d;
    end
  end

  always_ff @(posedge clk) begin
    if (en1_q) begin
      dat_q <= arr_data;
    end
  end

  always_comb begin
    stage_en = (mode == MODE_FLOW) ? en1_q : en2_q;
    rdata    = (mode == MODE_FLOW) ? arr_data : dat_q;
    drive_en = !out_en_n && !pwr_down && stage_en;
  end

  // R11: a held power-down keeps the bus undriven
  p_pd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && $past(pwr_down)) |-> !drive_en);
endmodule

// File: rtl/pbw_sram.sv
`timescale 1ns/1ps
module pbw_sram #(
  parameter int DEPTH  = 64,
  parameter int LANE_W = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = pbw_pkg::LANES * LANE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            addr,
  input  logic                     glob_wr_n,
  input  logic                     byte_wr_n,
  input  logic [pbw_pkg::LANES-1:0] lane_n,
  input  logic                     sel_n,
  input  logic                     proc_start,
  input  logic                     out_en_n,
  input  logic                     flow_thru,
  input  logic                     pwr_down,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic                     drive_en
);
  import pbw_pkg::*;

  logic [1:0]       rst_pipe;
  logic             rst_s;
  logic [LANES-1:0] wr_lanes;
  logic             rd_req;
  logic [AW-1:0]    a_q;
  logic [DW-1:0]    arr_q;
  rd_mode_e         mode_sel;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s = rst_pipe[1];

  pbw_we_decode #(.LANES(LANES)) u_dec (
    .live       (rst_s),
    .sel_n      (sel_n),
    .pwr_down   (pwr_down),
    .proc_start (proc_start),
    .glob_wr_n  (glob_wr_n),
    .byte_wr_n  (byte_wr_n),
    .lane_n     (lane_n),
    .wr_lanes   (wr_lanes),
    .rd_req     (rd_req)
  );

  // first pipeline stage: read address register
  always_ff @(posedge clk) begin
    if (rd_req) begin
      a_q <= addr;
    end
  end

  pbw_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk      (clk),
    .wr_lanes (wr_lanes),
    .wr_addr  (addr),
    .wr_data  (wdata),
    .rd_addr  (a_q),
    .rd_data  (arr_q)
  );

  assign mode_sel = flow_thru ? MODE_FLOW : MODE_PIPE;

  pbw_out_stage #(.DW(DW)) u_out (
    .clk      (clk),
    .rst_n    (rst_s),
    .rd_req   (rd_req),
    .arr_data (arr_q),
    .mode     (mode_sel),
    .pwr_down (pwr_down),
    .out_en_n (out_en_n),
    .rdata    (rdata),
    .drive_en (drive_en)
  );

  // R6: a write slot never drives, in either read mode
  p_wr_quiet_flow_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (flow_thru && $past(|wr_lanes)) |-> !drive_en);
  p_wr_quiet_pipe_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (!flow_thru && $past(|wr_lanes, 2)) |-> !drive_en);
  // R7: pipelined drive only two edges after an accepted read
  p_pipe_lat_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (!flow_thru && drive_en) |-> $past(rd_req, 2));
  // R10: a deselected cycle leaves its output slot undriven
  p_desel_pipe_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (!flow_thru && $past(sel_n, 2)) |-> !drive_en);
  p_desel_flow_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (flow_thru && $past(sel_n)) |-> !drive_en);
endmodule

// File: tb/sim_pbw_sram.sv
`timescale 1ns/1ps
module sim_pbw_sram;
  localparam int DEPTH  = 64;
  localparam int LANE_W = 9;
  localparam int LANES  = 4;
  localparam int AW     = $clog2(DEPTH);
  localparam int DW     = LANES * LANE_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [AW-1:0]    addr;
  logic             glob_wr_n, byte_wr_n, sel_n, proc_start;
  logic             out_en_n, flow_thru, pwr_down;
  logic [LANES-1:0] lane_n;
  logic [DW-1:0]    wdata, rdata;
  logic             drive_en;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] mdl [DEPTH];

  always #2.5 clk = ~clk;

  pbw_sram #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .glob_wr_n(glob_wr_n),
    .byte_wr_n(byte_wr_n), .lane_n(lane_n), .sel_n(sel_n),
    .proc_start(proc_start), .out_en_n(out_en_n), .flow_thru(flow_thru),
    .pwr_down(pwr_down), .wdata(wdata), .rdata(rdata), .drive_en(drive_en)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    sel_n = 1'b1; glob_wr_n = 1'b1; byte_wr_n = 1'b1;
    lane_n = '1; proc_start = 1'b0;
  endtask

  // one access; the model follows the write rules of R2..R5, R10, R11
  task automatic op(input logic [AW-1:0] a, input logic gw, input logic bw,
                    input logic [LANES-1:0] ln, input logic sn, input logic ps,
                    input logic [DW-1:0] d);
    logic [LANES-1:0] wl;
    @(negedge clk);
    addr = a; glob_wr_n = gw; byte_wr_n = bw; lane_n = ln;
    sel_n = sn; proc_start = ps; wdata = d;
    wl = '0;
    if (!sn && !pwr_down && !ps) wl = !gw ? '1 : (!bw ? ~ln : '0);
    for (int i = 0; i < LANES; i++)
      if (wl[i]) mdl[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
  endtask

  task automatic wr_all(input logic [AW-1:0] a, input logic [DW-1:0] d);
    op(a, 1'b0, 1'b1, '1, 1'b0, 1'b0, d);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    op(a, 1'b1, 1'b1, '1, 1'b0, 1'b0, '0);
  endtask

  // sample the output slot of the access just issued
  task automatic slot_chk(input string req, input bit exp_drv,
                          input bit cmp_data, input logic [DW-1:0] exp);
    if (!flow_thru) idle();
    @(negedge clk);
    chk(drive_en === exp_drv, req, DW'(drive_en), DW'(exp_drv));
    if (cmp_data) chk(rdata === exp, req, rdata, exp);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    rd(a);
    slot_chk(req, 1'b1, 1'b1, mdl[a]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(drive_en === 1'b0, "R1 in reset", DW'(drive_en), '0);
    rst_n = 1'b1;
    repeat (4) idle();
    @(negedge clk);
    chk(drive_en === 1'b0, "R1 after release", DW'(drive_en), '0);
  endtask

  task automatic t_global();
    wr_all(5, 36'h1_1111_1111);
    op(5, 1'b0, 1'b0, 4'b0101, 1'b0, 1'b0, 36'hA_BCDE_F012);
    rd(5);
    slot_chk("R2 global over lanes", 1'b1, 1'b1, 36'hA_BCDE_F012);
  endtask

  task automatic t_lanes();
    logic [DW-1:0] p, q;
    p = 36'h1_2345_6789; q = 36'hF_EDCB_A987;
    wr_all(9, p);
    op(9, 1'b1, 1'b0, 4'b1010, 1'b0, 1'b0, q);
    rd(9);
    slot_chk("R3 lanes 0 and 2", 1'b1, 1'b1,
             {p[35:27], q[26:18], p[17:9], q[8:0]});
  endtask

  task automatic t_nowrite();
    wr_all(12, 36'h5_5AA5_5AA5);
    op(12, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b0, 36'h0_0000_0000);
    slot_chk("R4 byte enable high acts as read", 1'b1, 1'b1, 36'h5_5AA5_5AA5);
    op(12, 1'b1, 1'b0, 4'b1111, 1'b0, 1'b0, 36'h0_0000_0000);
    slot_chk("R4 no lane selected acts as read", 1'b1, 1'b1, 36'h5_5AA5_5AA5);
  endtask

  task automatic t_proc();
    wr_all(20, 36'h3_0303_0303);
    op(20, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 36'hC_C0C0_C0C0);
    slot_chk("R5 processor start reads", 1'b1, 1'b1, 36'h3_0303_0303);
  endtask

  task automatic t_wr_quiet();
    wr_all(22, 36'h7_7777_0000);
    slot_chk("R6 write slot undriven pipe", 1'b0, 1'b0, '0);
    flow_thru = 1'b1;
    op(22, 1'b1, 1'b0, 4'b1110, 1'b0, 1'b0, 36'h0_0000_0042);
    slot_chk("R6 write slot undriven flow", 1'b0, 1'b0, '0);
    idle();
    flow_thru = 1'b0;
    idle();
  endtask

  task automatic t_pipe();
    wr_all(30, 36'h9_8765_4321);
    idle();
    rd(30);
    @(negedge clk);
    sel_n = 1'b1;
    chk(drive_en === 1'b0, "R7 not after first edge", DW'(drive_en), '0);
    @(negedge clk);
    chk(drive_en === 1'b1, "R7 driven after second edge", DW'(drive_en), 1);
    chk(rdata === 36'h9_8765_4321, "R7 pipelined data", rdata, 36'h9_8765_4321);
    @(negedge clk);
    chk(drive_en === 1'b0, "R7 single slot", DW'(drive_en), '0);
  endtask

  task automatic t_flow();
    wr_all(33, 36'h2_4681_3579);
    wr_all(34, 36'hE_0F0F_1E1E);
    idle();
    flow_thru = 1'b1;
    idle();
    rd(33);
    @(negedge clk);
    sel_n = 1'b1;
    chk(drive_en === 1'b1, "R8 driven after first edge", DW'(drive_en), 1);
    chk(rdata === 36'h2_4681_3579, "R8 flow data", rdata, 36'h2_4681_3579);
    rd_chk(34, "R8 second address");
    idle();
    flow_thru = 1'b0;
    idle();
  endtask

  task automatic t_oe();
    rd(30);
    idle();
    @(negedge clk);
    chk(drive_en === 1'b1, "R9 slot driven", DW'(drive_en), 1);
    out_en_n = 1'b1;
    #1;
    chk(drive_en === 1'b0, "R9 async disable", DW'(drive_en), '0);
    out_en_n = 1'b0;
    #1;
    chk(drive_en === 1'b1, "R9 async re-enable", DW'(drive_en), 1);
  endtask

  task automatic t_desel();
    wr_all(40, 36'h4_4444_4444);
    op(40, 1'b0, 1'b1, '1, 1'b1, 1'b0, 36'hB_BBBB_BBBB);
    slot_chk("R10 deselected slot undriven", 1'b0, 1'b0, '0);
    rd_chk(40, "R10 deselected write ignored");
  endtask

  task automatic t_pd();
    wr_all(41, 36'h6_1234_ABCD);
    idle();
    pwr_down = 1'b1;
    op(41, 1'b0, 1'b1, '1, 1'b0, 1'b0, 36'h0_DEAD_BEEF);
    slot_chk("R11 no drive in power-down", 1'b0, 1'b0, '0);
    rd(41);
    slot_chk("R11 read blocked in power-down", 1'b0, 1'b0, '0);
    idle();
    pwr_down = 1'b0;
    rd_chk(41, "R11 contents kept");
  endtask

  task automatic t_raw();
    logic [DW-1:0] p, q;
    p = 36'h8_1357_9BDF; q = 36'h1_FEDC_BA98;
    wr_all(50, p);
    op(50, 1'b1, 1'b0, 4'b1100, 1'b0, 1'b0, q);
    rd(50);
    slot_chk("R12 pipe read after write", 1'b1, 1'b1, {p[35:18], q[17:0]});
    wr_all(51, q);
    idle();
    flow_thru = 1'b1;
    op(51, 1'b1, 1'b0, 4'b0111, 1'b0, 1'b0, p);
    rd(51);
    slot_chk("R12 flow read after write", 1'b1, 1'b1, {p[35:27], q[26:0]});
    idle();
    flow_thru = 1'b0;
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    addr = '0; wdata = '0; glob_wr_n = 1'b1; byte_wr_n = 1'b1; lane_n = '1;
    sel_n = 1'b1; proc_start = 1'b0; out_en_n = 1'b0; flow_thru = 1'b0;
    pwr_down = 1'b0;
    t_reset();
    t_global();
    t_lanes();
    t_nowrite();
    t_proc();
    t_wr_quiet();
    t_pipe();
    t_flow();
    t_oe();
    t_desel();
    t_pd();
    t_raw();
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule